// File: doc/BRIEF.md
# AEGIS-128 State Update Core

This core keeps the 640-bit working state of the AEGIS-128 authenticated cipher as five 128-bit words and advances it by one update step for each 128-bit message word it accepts. An update runs five keyless AES rounds side by side. Each word is XORed with the round output of the word below it in the ring. The message word is also XORed into word 0, the word that receives the round output of word 4.

A host writes a full state image through the load port and reads the live state on the readback port at any time. Message words enter over a valid/ready handshake. The step completes in the clock cycle of the handshake, and a one-cycle done pulse follows. Key and nonce initialization, tag generation and framing of a message into words are left to the surrounding logic.

Top module: `aegis_state_update`

## Requirements
- R1: While rst_ni is low, the state reads as all zeros and done_o is low.
- R2: When load_i is high at a rising clock edge, state_o holds load_state_i from the next cycle on. Word k sits at bits [128k+127:128k]. Inside each word, byte j sits at bits [8j+7:8j] and is the AES state element at row j mod 4, column j div 4.
- R3: On an accepted message word, each new word k (k = 1..4) equals old word k XOR the round function of old word k-1.
- R4: On an accepted message word, the new word 0 equals old word 0 XOR the round function of old word 4 XOR msg_i.
- R5: The round function is one AES round with an all-zero round key, made of SubBytes, then ShiftRows (row r rotated left by r columns), then MixColumns. The round of an all-zero word is 0x63 in every byte.
- R6: Every round input in a step is a pre-step state value, so all five words change at the same clock edge.
- R7: msg_ready_o is low whenever load_i is high. A load and a presented message in the same cycle therefore result in the load only, with no update and no done pulse.
- R8: done_o is high for exactly the cycle that follows each accepted message word and is low otherwise.
- R9: With neither a load nor an accepted message word, the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Write the full state image |
| load_state_i | input | 640 | State image to write, word 0 in the low bits |
| state_o | output | 640 | Live state image, same layout |
| msg_valid_i | input | 1 | A message word is presented |
| msg_ready_o | output | 1 | The core can take a message word |
| msg_i | input | 128 | Message word |
| done_o | output | 1 | One-cycle pulse after an update |

## Verification
The case where two functions meet is a state load and a presented message word in the same cycle. The bench forces this collision on purpose, both in directed steps and often during a long random run in which load and valid are drawn independently. In each collision cycle, msg_ready_o must read low, the state in the next cycle must equal the loaded image with no trace of the message, and no done pulse may appear. A behavioural model of the cipher step predicts every one of these outcomes, and the outputs are compared against it in every cycle.

// File: rtl/aegis_pkg.sv
package aegis_pkg;
  localparam int unsigned WORD_W  = 128;
  localparam int unsigned N_WORDS = 5;
  localparam int unsigned STATE_W = WORD_W * N_WORDS;
  localparam int unsigned N_BYTES = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [7:0]        byte_t;

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t r = 8'h00;
    byte_t x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

  // a^254 is the multiplicative inverse, and it maps 0 to 0
  function automatic byte_t gf_inv(byte_t a);
    byte_t r = 8'h01;
    byte_t p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t sbox_calc(byte_t a);
    byte_t v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic byte_t xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aegis_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  always_comb byte_o = sbox_calc(byte_i);
endmodule

// File: rtl/aes_round_nokey.sv
module aes_round_nokey
  import aegis_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned N_COLS = N_BYTES / 4;

  logic [7:0] sub_b [N_BYTES];
  logic [7:0] shf_b [N_BYTES];

  for (genvar j = 0; j < N_BYTES; j++) begin : g_sub
    aes_sbox u_sbox (.byte_i(word_i[8*j +: 8]), .byte_o(sub_b[j]));
  end

  // byte index = 4*col + row
  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign shf_b[4*c+r] = sub_b[4*((c+r)%N_COLS)+r];
    end
    logic [7:0] a0, a1, a2, a3;
    assign a0 = shf_b[4*c+0];
    assign a1 = shf_b[4*c+1];
    assign a2 = shf_b[4*c+2];
    assign a3 = shf_b[4*c+3];
    assign word_o[32*c+0  +: 8] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign word_o[32*c+8  +: 8] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign word_o[32*c+16 +: 8] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign word_o[32*c+24 +: 8] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  // R5 known answer: all-zero input gives 0x63 in every byte
  always_comb begin
    if (word_i == '0) a_r5_zero_round: assert (word_o == {N_BYTES{8'h63}});
  end
endmodule

// File: rtl/aegis_update_dp.sv
module aegis_update_dp
  import aegis_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  input  logic [WORD_W-1:0]  msg_i,
  output logic [STATE_W-1:0] state_o
);
  logic [WORD_W-1:0] rnd_out [N_WORDS];

  for (genvar k = 0; k < N_WORDS; k++) begin : g_lane
    localparam int unsigned SRC = (k + N_WORDS - 1) % N_WORDS;
    aes_round_nokey u_round (
      .word_i(state_i[WORD_W*k +: WORD_W]),
      .word_o(rnd_out[k])
    );
    if (k == 0) begin : g_inj
      assign state_o[WORD_W*k +: WORD_W] = state_i[WORD_W*k +: WORD_W] ^ rnd_out[SRC] ^ msg_i;
    end else begin : g_plain
      assign state_o[WORD_W*k +: WORD_W] = state_i[WORD_W*k +: WORD_W] ^ rnd_out[SRC];
    end
  end
endmodule

// File: rtl/aegis_state_update.sv
module aegis_state_update
  import aegis_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] load_state_i,
  output logic [STATE_W-1:0] state_o,
  input  logic               msg_valid_i,
  output logic               msg_ready_o,
  input  logic [WORD_W-1:0]  msg_i,
  output logic               done_o
);
  logic [STATE_W-1:0] state_q, state_nxt;
  logic               done_q;
  logic               accept;

  assign msg_ready_o = ~load_i;
  assign accept      = msg_valid_i & msg_ready_o;

  aegis_update_dp u_dp (
    .state_i(state_q),
    .msg_i  (msg_i),
    .state_o(state_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= accept;
      if (load_i)      state_q <= load_state_i;
      else if (accept) state_q <= state_nxt;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  a_r2_load_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_o == $past(load_state_i));
  a_r7_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && msg_valid_i) |=> !done_o);
  a_r8_done_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && msg_ready_o) |=> done_o);
  a_r8_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(msg_valid_i && msg_ready_o));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !msg_valid_i) |=> $stable(state_o));
endmodule

// File: tb/tb_aegis_state_update.sv
`timescale 1ns/1ps
module tb_aegis_state_update;
  localparam int SW = 640;
  localparam int WW = 128;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_i = 1'b0;
  logic [SW-1:0] load_state_i = '0;
  logic [SW-1:0] state_o;
  logic          msg_valid_i = 1'b0;
  logic          msg_ready_o;
  logic [WW-1:0] msg_i = '0;
  logic          done_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  aegis_state_update dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_state_i(load_state_i),
    .state_o(state_o), .msg_valid_i(msg_valid_i), .msg_ready_o(msg_ready_o),
    .msg_i(msg_i), .done_o(done_o)
  );

  // reference S-box built by walking the multiplicative group
  logic [7:0] sb [256];
  initial begin
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ ((p & 8'h80) != 0 ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if ((q & 8'h80) != 0) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  end

  function automatic logic [7:0] mul2(logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [WW-1:0] ref_round(logic [WW-1:0] w);
    logic [7:0] s [16];
    logic [WW-1:0] res;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        s[4*c+r] = sb[w[8*(4*((c+r)%4)+r) +: 8]];
    for (int c = 0; c < 4; c++) begin
      logic [7:0] t;
      t = s[4*c] ^ s[4*c+1] ^ s[4*c+2] ^ s[4*c+3];
      for (int r = 0; r < 4; r++)
        res[8*(4*c+r) +: 8] = s[4*c+r] ^ t ^ mul2(s[4*c+r] ^ s[4*c+(r+1)%4]);
    end
    return res;
  endfunction

  // behavioural model
  logic [WW-1:0] m_w [5];
  logic          m_done = 1'b0;
  string         m_tag = "R1";
  initial for (int k = 0; k < 5; k++) m_w[k] = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 5; k++) m_w[k] = '0;
      m_done = 1'b0;
      m_tag  = "R1";
    end else if (load_i) begin
      for (int k = 0; k < 5; k++) m_w[k] = load_state_i[WW*k +: WW];
      m_done = 1'b0;
      m_tag  = msg_valid_i ? "R7" : "R2";
    end else if (msg_valid_i) begin
      logic [WW-1:0] o [5];
      for (int k = 0; k < 5; k++) o[k] = m_w[k];
      for (int k = 1; k < 5; k++) m_w[k] = o[k] ^ ref_round(o[k-1]);
      m_w[0] = o[0] ^ ref_round(o[4]) ^ msg_i;
      m_done = 1'b1;
      m_tag  = "R3/R4/R6";
    end else begin
      m_done = 1'b0;
      m_tag  = "R9";
    end
  end

  always @(negedge clk_i) begin
    #1;
    for (int k = 0; k < 5; k++) begin
      checks++;
      if (state_o[WW*k +: WW] !== m_w[k]) begin
        errors++;
        $display("FAIL %s word %0d: actual %h expected %h", m_tag, k, state_o[WW*k +: WW], m_w[k]);
      end
    end
    checks++;
    if (done_o !== m_done) begin
      errors++;
      $display("FAIL R8 (%s): done actual %b expected %b", m_tag, done_o, m_done);
    end
    checks++;
    if (msg_ready_o !== !load_i) begin
      errors++;
      $display("FAIL R7: ready actual %b expected %b", msg_ready_o, !load_i);
    end
  end

  task automatic drive(input logic ld, input logic [SW-1:0] img, input logic vld, input logic [WW-1:0] m);
    @(negedge clk_i);
    load_i = ld; load_state_i = img; msg_valid_i = vld; msg_i = m;
  endtask

  task automatic direct(input string tag, input logic [SW-1:0] exp_s);
    @(negedge clk_i);
    #2;
    checks++;
    if (state_o !== exp_s) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, state_o, exp_s);
    end
  endtask

  function automatic logic [SW-1:0] rnd_img();
    logic [SW-1:0] v;
    for (int i = 0; i < SW/32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [WW-1:0] rnd_msg();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : watchdog
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [SW-1:0] img;
    logic [WW-1:0] m;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    checks++;
    if (state_o !== '0 || done_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: state %h done %b expected 0", state_o, done_o);
    end
    rst_ni = 1'b1;
    // R5/R6: zero state, zero message -> every byte 0x63
    drive(1'b1, '0, 1'b0, '0);
    drive(1'b0, '0, 1'b1, '0);
    drive(1'b0, '0, 1'b0, '0);
    direct("R5", {80{8'h63}});
    // R4: message lands in word 0 only
    m = 128'h00112233_44556677_8899aabb_ccddeeff;
    drive(1'b1, '0, 1'b0, '0);
    drive(1'b0, '0, 1'b1, m);
    drive(1'b0, '0, 1'b0, '0);
    direct("R4", {{64{8'h63}}, {16{8'h63}} ^ m});
    // R7: collision, load wins
    img = rnd_img();
    drive(1'b1, img, 1'b1, rnd_msg());
    drive(1'b0, '0, 1'b0, '0);
    direct("R7", img);
    // R9: idle holds with message data toggling but valid low
    drive(1'b0, rnd_img(), 1'b0, rnd_msg());
    drive(1'b0, rnd_img(), 1'b0, rnd_msg());
    direct("R9", img);
    // back-to-back updates
    for (int i = 0; i < 8; i++) drive(1'b0, '0, 1'b1, rnd_msg());
    // random mix
    for (int i = 0; i < 400; i++) begin
      int u;
      u = $urandom_range(0, 99);
      drive(u < 15, rnd_img(), $urandom_range(0, 99) < 60, rnd_msg());
    end
    drive(1'b0, '0, 1'b0, '0);
    // mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    direct("R1", '0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule